// File: doc/BRIEF.md
# Response-Keyed GF(2) Matrix Authentication Engine

This block carries out one side of a challenge-response authentication round. Both parties hold the same secret bit matrix `A`, of size N by N. Each round first changes `A` using a device-unique response function, then proves that both sides hold the same matrix. The engine sends its own pseudo-random nonce and takes in the peer's nonce. It joins the two nonces into a challenge and passes that challenge through a keyed network of 4-input lookup tables. The lookup tables produce an N by N response matrix `R`, and `A` is replaced by `A·R` over GF(2). If that product is the zero matrix, `A` is reloaded with a non-zero constant and the nonce exchange starts again. Once the round has a non-zero matrix, a random column vector `x` is multiplied by `A`. In verifier mode the engine sends `x` and compares the peer's product with its own. In client mode it takes in `x` and returns its product.

All words leave on one valid/ready channel (`tx_*`) and arrive on another (`rx_*`). A word moves on a rising clock edge at which both valid and ready are high. While `tx_valid` is high and `tx_ready` is low, the engine holds `tx_data` unchanged and keeps `tx_valid` high, for as many cycles as the peer stalls. The engine raises `rx_ready` only in a state that waits for a word, and it never offers and accepts a word in the same cycle. `start`, `is_verifier`, `done` and `pass` are plain level signals. `done` pulses for one cycle at the end of a round, and `pass` is valid in that cycle.

Top module: `puf_matauth_engine`

## Requirements
- R1: While `rst_n` is low, `tx_valid`, `rx_ready` and `done` are low, `A` is loaded with the parameter `A_INIT`, and the nonce generator is loaded with `seed`, or with 1 if `seed` is zero.
- R2: When `start` is high in the idle state, the engine offers its nonce on `tx_data`. The nonce is the current 16-bit generator state `s`. The generator steps once for each nonce word and each vector word that is accepted, and the step is `s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}`.
- R3: Under back-pressure the offered word and `tx_valid` stay unchanged. `rx_ready` and `tx_valid` are never high together.
- R4: The 32-bit challenge is `{verifier_nonce, client_nonce}`, with the verifier's nonce in bits 31:16. In verifier mode the engine's own nonce is the verifier nonce; in client mode it is the client nonce.
- R5: Matrix element (i,j) sits at bit k = i·N+j. Response bit k is `KEY[16k + a]`, where the 4-bit address is a = {c[(4k+3)%32], c[(4k+2)%32], c[(4k+1)%32], c[(4k)%32]} and c is the challenge.
- R6: After the peer nonce is accepted, `A` becomes `A·R` over GF(2): element (i,j) is the XOR over k of A(i,k) AND R(k,j).
- R7: If `A·R` is all zero, `A` is reloaded with `A_INIT` and the engine offers a new nonce and waits for a new peer nonce. It sends no vector first.
- R8: A verifier sends `x` as the low N bits of the generator state, with zeros above. A client takes `x` from the low N bits of the received word and ignores the upper bits.
- R9: `b = A·x`, with bit i being the XOR over j of A(i,j) AND x(j). A client sends `b` with zeros above and then pulses `done` with `pass` = 1.
- R10: A verifier compares the low N bits of the received word with its own `b`. It pulses `done` with `pass` = 1 if they are equal and with `pass` = 0 otherwise. The upper bits of that word are ignored.
- R11: `done` is high for exactly one cycle per round. `A` is carried over into the next round and is not reloaded between rounds.
- R12: `start` has no effect while a round is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed | input | 16 | Nonce generator seed, loaded during reset |
| start | input | 1 | Begin a round (sampled only when idle) |
| is_verifier | input | 1 | Role for the round: 1 verifier, 0 client |
| tx_valid | output | 1 | Outgoing word is valid |
| tx_ready | input | 1 | Peer accepts the outgoing word |
| tx_data | output | 16 | Outgoing nonce, vector or product |
| rx_valid | input | 1 | Incoming word is valid |
| rx_ready | output | 1 | Engine accepts an incoming word |
| rx_data | input | 16 | Incoming nonce, vector or product |
| done | output | 1 | One-cycle end-of-round pulse |
| pass | output | 1 | Authentication result, valid with `done` |

## Verification
The bench plays the peer for well over a hundred rounds, alternating roles, and keeps its own arithmetic model of the generator, the lookup-table response and both GF(2) products. In client rounds the vector takes all sixteen values, which shows whether every column of the evolved matrix is wired into the product. Peer nonces change from round to round, so mistakes in the challenge order and the table addressing show up as wrong later products. A zero peer nonce right after reset forces a zero product and tells a working restart apart from a vector being sent too early. In verifier rounds the returned product is correct, has one bit flipped, or has only its upper bits corrupted. These three cases separate a true comparison from one that is too strict or too loose, while stalls of varying length on the ready signals exercise back-pressure.

// File: rtl/puf_auth_pkg.sv
package puf_auth_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_NONCE,
    ST_RX_NONCE,
    ST_MIX,
    ST_TX_VEC,
    ST_RX_VEC,
    ST_TX_PROD,
    ST_RX_PROD,
    ST_DONE
  } auth_state_t;
endpackage

// File: rtl/nonce_lfsr.sv
module nonce_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= (seed == '0) ? W'(1) : seed;
    else if (adv) st_q <= {st_q[W-2:0], ^(st_q & TAPS)};
  end

  assign state = st_q;

  // R2: a maximal-length generator must never fall into the all-zero lock state
  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0)
    else $error("generator reached zero");
endmodule

// File: rtl/lut_response.sv
module lut_response #(
  parameter int                 N   = 4,
  parameter int                 CW  = 32,
  parameter logic [N*N*16-1:0]  KEY = '0
) (
  input  logic [CW-1:0]  chal,
  output logic [N*N-1:0] resp
);
  localparam int MW = N * N;

  for (genvar k = 0; k < MW; k++) begin : g_lut
    localparam logic [15:0] TBL = KEY[k*16 +: 16];
    logic [3:0] addr;
    assign addr = {chal[(4*k+3) % CW], chal[(4*k+2) % CW],
                   chal[(4*k+1) % CW], chal[(4*k) % CW]};
    assign resp[k] = TBL[addr];
  end
endmodule

// File: rtl/gf2_matmul.sv
module gf2_matmul #(
  parameter int N = 4
) (
  input  logic [N*N-1:0] a,
  input  logic [N*N-1:0] b,
  output logic [N*N-1:0] c
);
  for (genvar j = 0; j < N; j++) begin : g_col
    logic [N-1:0] col;
    for (genvar k = 0; k < N; k++) begin : g_pick
      assign col[k] = b[k*N + j];
    end
    for (genvar i = 0; i < N; i++) begin : g_row
      assign c[i*N + j] = ^(a[i*N +: N] & col);
    end
  end
endmodule

// File: rtl/gf2_matvec.sv
module gf2_matvec #(
  parameter int N = 4
) (
  input  logic [N*N-1:0] a,
  input  logic [N-1:0]   x,
  output logic [N-1:0]   y
);
  for (genvar i = 0; i < N; i++) begin : g_row
    assign y[i] = ^(a[i*N +: N] & x);
  end
endmodule

// File: rtl/puf_matauth_engine.sv
module puf_matauth_engine
  import puf_auth_pkg::*;
#(
  parameter int                N        = 4,
  parameter int                W        = 16,
  parameter logic [W-1:0]      LFSR_TAP = 16'hB400,
  parameter logic [N*N*16-1:0] KEY      = {16{16'h6A3C}},
  parameter logic [N*N-1:0]    A_INIT   = 16'h8421
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  input  logic         start,
  input  logic         is_verifier,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [W-1:0] tx_data,
  input  logic         rx_valid,
  output logic         rx_ready,
  input  logic [W-1:0] rx_data,
  output logic         done,
  output logic         pass
);
  localparam int CW = 2 * W;
  localparam int MW = N * N;

  auth_state_t   st_q;
  logic          role_q;
  logic [W-1:0]  own_q, peer_q;
  logic [MW-1:0] mat_q;
  logic [N-1:0]  vec_q;
  logic          pass_q;

  logic [W-1:0]  lfsr_s;
  logic [CW-1:0] chal;
  logic [MW-1:0] resp, prod;
  logic [N-1:0]  bvec;
  logic          tx_fire, rx_fire, adv;

  assign tx_valid = (st_q == ST_TX_NONCE) || (st_q == ST_TX_VEC) || (st_q == ST_TX_PROD);
  assign rx_ready = (st_q == ST_RX_NONCE) || (st_q == ST_RX_VEC) || (st_q == ST_RX_PROD);
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_fire  = rx_valid && rx_ready;
  assign adv      = tx_fire && (st_q != ST_TX_PROD);
  assign done     = (st_q == ST_DONE);
  assign pass     = pass_q;

  always_comb begin
    case (st_q)
      ST_TX_VEC:  tx_data = {{(W-N){1'b0}}, lfsr_s[N-1:0]};
      ST_TX_PROD: tx_data = {{(W-N){1'b0}}, bvec};
      default:    tx_data = lfsr_s;
    endcase
  end

  assign chal = role_q ? {own_q, peer_q} : {peer_q, own_q};

  nonce_lfsr #(.W(W), .TAPS(LFSR_TAP)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed(seed), .adv(adv), .state(lfsr_s)
  );

  lut_response #(.N(N), .CW(CW), .KEY(KEY)) u_resp (.chal(chal), .resp(resp));

  gf2_matmul #(.N(N)) u_mul (.a(mat_q), .b(resp), .c(prod));

  gf2_matvec #(.N(N)) u_vec (.a(mat_q), .x(vec_q), .y(bvec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      role_q <= 1'b0;
      own_q  <= '0;
      peer_q <= '0;
      mat_q  <= A_INIT;
      vec_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          role_q <= is_verifier;
          st_q   <= ST_TX_NONCE;
        end
        ST_TX_NONCE: if (tx_fire) begin
          own_q <= lfsr_s;
          st_q  <= ST_RX_NONCE;
        end
        ST_RX_NONCE: if (rx_fire) begin
          peer_q <= rx_data;
          st_q   <= ST_MIX;
        end
        ST_MIX: begin
          if (prod == '0) begin
            mat_q <= A_INIT;
            st_q  <= ST_TX_NONCE;
          end else begin
            mat_q <= prod;
            st_q  <= role_q ? ST_TX_VEC : ST_RX_VEC;
          end
        end
        ST_TX_VEC: if (tx_fire) begin
          vec_q <= lfsr_s[N-1:0];
          st_q  <= ST_RX_PROD;
        end
        ST_RX_VEC: if (rx_fire) begin
          vec_q <= rx_data[N-1:0];
          st_q  <= ST_TX_PROD;
        end
        ST_TX_PROD: if (tx_fire) begin
          pass_q <= 1'b1;
          st_q   <= ST_DONE;
        end
        ST_RX_PROD: if (rx_fire) begin
          pass_q <= (rx_data[N-1:0] == bvec);
          st_q   <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: an offered word is held while the peer stalls
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
    else $error("tx word changed under back-pressure");

  // R3: never offering and accepting in the same cycle
  p_no_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready))
    else $error("tx and rx active together");

  // R7: the held secret matrix is never the zero matrix
  p_mat_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mat_q != '0)
    else $error("secret matrix became zero");

  // R11: end-of-round pulse lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  // R8: a vector word carries zeros above the low N bits
  p_vec_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_VEC || st_q == ST_TX_PROD) |-> (tx_data[W-1:N] == '0))
    else $error("vector word upper bits not zero");
endmodule

// File: tb/puf_matauth_engine_test.sv
module puf_matauth_engine_test;
  localparam int N = 4;
  localparam int W = 16;
  localparam logic [255:0] TB_KEY =
    256'h3C5A_96E2_71B4_0FD8_A5C6_2E98_D374_6B1E_58AC_E0F2_94D6_1B7A_C3E4_7A50_2D96_B8F4;
  localparam logic [15:0] TB_AINIT = 16'h0401;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] seed = 16'hACE1;
  logic start = 1'b0, is_verifier = 1'b0;
  logic tx_valid, tx_ready = 1'b0;
  logic [W-1:0] tx_data;
  logic rx_valid = 1'b0, rx_ready;
  logic [W-1:0] rx_data = '0;
  logic done, pass;

  int errors = 0, checks = 0, cyc = 0, restarts = 0, stall_n = 0;
  logic [15:0] ms;
  logic [15:0] ma;
  bit glitch_start = 1'b0;

  always #4 clk = ~clk;

  puf_matauth_engine #(.N(N), .W(W), .KEY(TB_KEY), .A_INIT(TB_AINIT)) uut (
    .clk(clk), .rst_n(rst_n), .seed(seed), .start(start), .is_verifier(is_verifier),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .done(done), .pass(pass)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [15:0] resp_of(input logic [31:0] c);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] a;
      a = {c[(4*k+3) % 32], c[(4*k+2) % 32], c[(4*k+1) % 32], c[(4*k) % 32]};
      r[k] = TB_KEY[k*16 + int'(a)];
    end
    return r;
  endfunction

  function automatic logic [15:0] mmul(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] c;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        logic acc;
        acc = 1'b0;
        for (int k = 0; k < 4; k++) acc = acc ^ (a[i*4+k] & b[k*4+j]);
        c[i*4+j] = acc;
      end
    return c;
  endfunction

  function automatic logic [3:0] mvec(input logic [15:0] a, input logic [3:0] x);
    logic [3:0] y;
    for (int i = 0; i < 4; i++) begin
      logic acc;
      acc = 1'b0;
      for (int j = 0; j < 4; j++) acc = acc ^ (a[i*4+j] & x[j]);
      y[i] = acc;
    end
    return y;
  endfunction

  task automatic get_word(output logic [W-1:0] w);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    for (int s = 0; s < stall_n; s++) @(negedge clk);
    tx_ready = 1'b1;
    w = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic put_word(input logic [W-1:0] w);
    @(negedge clk);
    for (int s = 0; s < stall_n; s++) @(negedge clk);
    rx_valid = 1'b1;
    rx_data = w;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [15:0] sd);
    @(negedge clk);
    rst_n = 1'b0;
    seed = sd;
    @(negedge clk);
    @(negedge clk);
    chk(tx_valid == 1'b0 && rx_ready == 1'b0 && done == 1'b0, "R1 reset outputs",
        {29'd0, tx_valid, rx_ready, done}, 32'd0);
    rst_n = 1'b1;
    ms = (sd == 16'h0) ? 16'h0001 : sd;
    ma = TB_AINIT;
  endtask

  task automatic run_round(input bit ver, input int rid, input logic [15:0] first_pn);
    logic [W-1:0] w, pn;
    logic [15:0] nm;
    logic [3:0] xv, bv;
    int att;
    bit ok_exp;
    is_verifier = ver;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    att = 0;
    forever begin
      get_word(w);
      chk(w == ms, (att == 0) ? "R2 nonce value" : "R7 fresh nonce after restart", 32'(w), 32'(ms));
      ms = step(ms);
      pn = (att == 0) ? first_pn : (first_pn ^ 16'(16'h1357 * att));
      if (glitch_start) begin
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      put_word(pn);
      nm = mmul(ma, resp_of(ver ? {w, pn} : {pn, w}));
      if (nm == 16'h0) begin
        ma = TB_AINIT;
        restarts = restarts + 1;
        att = att + 1;
        if (att > 8) begin
          chk(1'b0, "R7 restart bound", 32'(att), 32'd8);
          return;
        end
      end else begin
        ma = nm;
        break;
      end
    end
    if (ver) begin
      get_word(w);
      chk(w == {12'h000, ms[3:0]}, "R8 verifier vector word", 32'(w), {28'd0, ms[3:0]});
      xv = ms[3:0];
      ms = step(ms);
      bv = mvec(ma, xv);
      case (rid % 3)
        0: begin put_word({12'h000, bv}); ok_exp = 1'b1; end
        1: begin put_word({12'h000, bv ^ 4'(1 << (rid % 4))}); ok_exp = 1'b0; end
        default: begin put_word({12'hA5C, bv}); ok_exp = 1'b1; end
      endcase
      chk(done == 1'b1 && pass == ok_exp, "R10 verifier done/pass",
          {30'd0, done, pass}, {30'd0, 1'b1, ok_exp});
    end else begin
      xv = 4'(rid / 2);
      put_word({12'h9B3, xv});
      get_word(w);
      chk(w == {12'h000, mvec(ma, xv)}, "R9 client product word (R6 R5 R4 chain)",
          32'(w), {28'd0, mvec(ma, xv)});
      chk(done == 1'b1 && pass == 1'b1, "R9 client done/pass", {30'd0, done, pass}, 32'd3);
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int r0;
    do_reset(16'hACE1);
    // R7: first round after reset with a zero peer nonce forces A*R = 0
    r0 = restarts;
    run_round(1'b1, 0, 16'h0000);
    chk(restarts >= r0 + 1, "R7 zero product restarts the round", 32'(restarts - r0), 32'd1);
    // sweep: alternating roles, every vector value, varied stalls; A carried over (R11)
    for (int rid = 1; rid <= 128; rid++) begin
      stall_n = rid % 3;
      glitch_start = (rid % 17 == 5);   // R12: start pulses during a round
      run_round(rid % 2 == 0, rid, 16'(rid * 16'h0F1D + 1));
    end
    glitch_start = 1'b0;
    stall_n = 0;
    // R1: zero seed maps to state 1; A reloaded on reset
    do_reset(16'h0000);
    chk(ms == 16'h0001, "R1 zero seed model", 32'(ms), 32'd1);
    run_round(1'b1, 3, 16'h4321);
    run_round(1'b0, 6, 16'h8765);
    run_round(1'b1, 9, 16'h0000);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule